// File: doc/BRIEF.md
# Deferred-Compare Condition Evaluator

This block decides whether an instruction may execute. It looks at the 4-bit condition code in the top bits of the instruction word. It holds no architectural N/Z/C/V flag bits. Instead it keeps the two operands of the most recent flag-setting operation, plus a mode that says how the operands relate: compare, bitwise test or test-equivalence. On every query it evaluates the condition from that stored pair.

The update side is a single-cycle strobe. Each cycle in which the strobe is high is taken as one completed data-processing operation. The strobe carries the operation code, the S bit, both operands and the ALU result. There is no back-pressure: the block accepts every strobe, and an update can never be refused or stalled.

The query side is purely combinational. An instruction word goes in, and an execute decision and an undefined-trap indication come out in the same cycle. A trap always suppresses execution. The ALU, instruction fetch and the trap handler all sit outside this block.

Top module: `defcmp_cond`

## Requirements
- R1: The condition code is bits [IW-1:IW-4] of `q_instr`. All lower bits have no effect on the outputs.
- R2: Code 14 always gives execute=1 and undef=0. Code 15 always gives execute=0 and undef=0. Both hold in every mode.
- R3: In compare mode with stored pair (x,y), the codes resolve as follows:
  - 0 executes when x==y, and 1 executes when x!=y.
  - 2 (x>=y), 3 (x<y), 8 (x>y) and 9 (x<=y) compare unsigned.
  - 10 (x>=y), 11 (x<y), 12 (x>y) and 13 (x<=y) compare signed.
- R4: In compare mode, code 4 executes when bit DW-1 of the DW-bit difference x-y is 1. Code 5 executes when that bit is 0.
- R5: In compare mode, codes 6 and 7 assert undef and give execute=0. Undef never coincides with execute.
- R6: In test mode the value v is x AND y. In test-equivalence mode v is x XOR y. In both modes the codes resolve as follows:
  - 0 executes when v==0, and 1 executes when v!=0.
  - 4 executes when v[DW-1]=1, and 5 executes when v[DW-1]=0.
  - 14 and 15 behave as in R2.
  - Every other code asserts undef with execute=0.
- R7: A flag-setting update in compare mode stores its pair according to the op code:
  - SUB (op 2) and CMP (op 10) store (a,b).
  - RSB (op 3) stores (b,a).
  - CMN (op 11) stores (a,-b).
  - ADD (op 4) stores (b,-a).
- R8: A flag-setting AND (0), EOR (1), ORR (12), MOV (13), BIC (14) or MVN (15) stores (result,0) in compare mode. A flag-setting TST (8) stores (a,b) in test mode, and TEQ (9) stores (a,b) in test-equivalence mode.
- R9: The stored state is left unchanged in three cases: the strobe is low, the S bit is 0, or the op code is 5, 6 or 7.
- R10: After reset the state is compare mode with x=y=0. An update becomes visible on the query outputs only after the clock edge that samples the strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| upd_valid | input | 1 | Strobe that marks one completed operation |
| upd_op | input | 4 | Data-processing op code |
| upd_s | input | 1 | Flag-setting bit of the operation |
| upd_a | input | DW | First operand |
| upd_b | input | DW | Second operand, after any shift |
| upd_res | input | DW | ALU result |
| q_instr | input | IW | Instruction word being queried |
| q_exec | output | 1 | The instruction may execute |
| q_undef | output | 1 | Undefined-condition trap |

## Verification
The stored pair cannot be read directly. It can only be inferred through the condition outputs, so an update with a wrong operand order or a missing negation shows up only on some codes and some operand values. The subtle cases are where x-y wraps the sign bit, and where an operand is the most negative value, whose negation is itself. To reach them, the stimulus walks every op code, with the S bit both clear and set, over a grid of operand pairs that includes 0x7F and 0x80. After each update it queries all sixteen codes, with changing junk in the lower instruction bits. It also queries every code once more before the clock edge, to confirm that the old state still governs the outputs.

// File: rtl/dc_pkg.sv
package dc_pkg;
  typedef enum logic [1:0] {
    M_CMP = 2'd0,
    M_AND = 2'd1,
    M_XOR = 2'd2
  } dc_mode_e;

  localparam logic [3:0] OP_AND = 4'd0;
  localparam logic [3:0] OP_EOR = 4'd1;
  localparam logic [3:0] OP_SUB = 4'd2;
  localparam logic [3:0] OP_RSB = 4'd3;
  localparam logic [3:0] OP_ADD = 4'd4;
  localparam logic [3:0] OP_TST = 4'd8;
  localparam logic [3:0] OP_TEQ = 4'd9;
  localparam logic [3:0] OP_CMP = 4'd10;
  localparam logic [3:0] OP_CMN = 4'd11;
  localparam logic [3:0] OP_ORR = 4'd12;
  localparam logic [3:0] OP_MOV = 4'd13;
  localparam logic [3:0] OP_BIC = 4'd14;
  localparam logic [3:0] OP_MVN = 4'd15;

  localparam int CW = 4;
endpackage

// File: rtl/dc_update.sv
module dc_update
  import dc_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic           upd_valid,
  input  logic [3:0]     upd_op,
  input  logic           upd_s,
  input  logic [DW-1:0]  upd_a,
  input  logic [DW-1:0]  upd_b,
  input  logic [DW-1:0]  upd_res,
  input  dc_mode_e       cur_mode,
  input  logic [DW-1:0]  cur_x,
  input  logic [DW-1:0]  cur_y,
  output dc_mode_e       nxt_mode,
  output logic [DW-1:0]  nxt_x,
  output logic [DW-1:0]  nxt_y
);
  localparam logic [DW-1:0] ZERO = '0;

  always_comb begin
    nxt_mode = cur_mode;
    nxt_x    = cur_x;
    nxt_y    = cur_y;
    if (upd_valid && upd_s) begin
      unique case (upd_op)
        OP_SUB, OP_CMP: begin
          nxt_mode = M_CMP; nxt_x = upd_a; nxt_y = upd_b;
        end
        OP_RSB: begin
          nxt_mode = M_CMP; nxt_x = upd_b; nxt_y = upd_a;
        end
        OP_CMN: begin
          nxt_mode = M_CMP; nxt_x = upd_a; nxt_y = ZERO - upd_b;
        end
        OP_ADD: begin
          nxt_mode = M_CMP; nxt_x = upd_b; nxt_y = ZERO - upd_a;
        end
        OP_TST: begin
          nxt_mode = M_AND; nxt_x = upd_a; nxt_y = upd_b;
        end
        OP_TEQ: begin
          nxt_mode = M_XOR; nxt_x = upd_a; nxt_y = upd_b;
        end
        OP_AND, OP_EOR, OP_ORR, OP_MOV, OP_BIC, OP_MVN: begin
          nxt_mode = M_CMP; nxt_x = upd_res; nxt_y = ZERO;
        end
        default: begin
          nxt_mode = cur_mode;
        end
      endcase
    end
  end
endmodule

// File: rtl/dc_eval.sv
module dc_eval
  import dc_pkg::*;
#(
  parameter int DW = 32
) (
  input  dc_mode_e       mode,
  input  logic [DW-1:0]  x,
  input  logic [DW-1:0]  y,
  input  logic [CW-1:0]  cond,
  output logic           ev_exec,
  output logic           ev_undef
);
  logic [DW-1:0] diff;
  logic [DW-1:0] tval;

  assign diff = x - y;
  assign tval = (mode == M_AND) ? (x & y) : (x ^ y);

  always_comb begin
    ev_exec  = 1'b0;
    ev_undef = 1'b0;
    if (mode == M_CMP) begin
      unique case (cond)
        4'd0:  ev_exec = (x == y);
        4'd1:  ev_exec = (x != y);
        4'd2:  ev_exec = (x >= y);
        4'd3:  ev_exec = (x < y);
        4'd4:  ev_exec = diff[DW-1];
        4'd5:  ev_exec = !diff[DW-1];
        4'd6, 4'd7: ev_undef = 1'b1;
        4'd8:  ev_exec = (x > y);
        4'd9:  ev_exec = (x <= y);
        4'd10: ev_exec = ($signed(x) >= $signed(y));
        4'd11: ev_exec = ($signed(x) < $signed(y));
        4'd12: ev_exec = ($signed(x) > $signed(y));
        4'd13: ev_exec = ($signed(x) <= $signed(y));
        4'd14: ev_exec = 1'b1;
        default: ev_exec = 1'b0;
      endcase
    end else begin
      unique case (cond)
        4'd0:  ev_exec = (tval == '0);
        4'd1:  ev_exec = (tval != '0);
        4'd4:  ev_exec = tval[DW-1];
        4'd5:  ev_exec = !tval[DW-1];
        4'd14: ev_exec = 1'b1;
        4'd15: ev_exec = 1'b0;
        default: ev_undef = 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/defcmp_cond.sv
module defcmp_cond
  import dc_pkg::*;
#(
  parameter int DW = 32,
  parameter int IW = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           upd_valid,
  input  logic [3:0]     upd_op,
  input  logic           upd_s,
  input  logic [DW-1:0]  upd_a,
  input  logic [DW-1:0]  upd_b,
  input  logic [DW-1:0]  upd_res,
  input  logic [IW-1:0]  q_instr,
  output logic           q_exec,
  output logic           q_undef
);
  dc_mode_e      st_mode, nx_mode;
  logic [DW-1:0] st_x, st_y, nx_x, nx_y;
  logic [CW-1:0] cond_code;

  assign cond_code = q_instr[IW-1 -: CW];

  dc_update #(.DW(DW)) u_upd (
    .upd_valid(upd_valid), .upd_op(upd_op), .upd_s(upd_s),
    .upd_a(upd_a), .upd_b(upd_b), .upd_res(upd_res),
    .cur_mode(st_mode), .cur_x(st_x), .cur_y(st_y),
    .nxt_mode(nx_mode), .nxt_x(nx_x), .nxt_y(nx_y)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_mode <= M_CMP;
      st_x    <= '0;
      st_y    <= '0;
    end else begin
      st_mode <= nx_mode;
      st_x    <= nx_x;
      st_y    <= nx_y;
    end
  end

  dc_eval #(.DW(DW)) u_eval (
    .mode(st_mode), .x(st_x), .y(st_y), .cond(cond_code),
    .ev_exec(q_exec), .ev_undef(q_undef)
  );
endmodule

// File: rtl/dc_chk.sv
module dc_chk #(
  parameter int DW = 32,
  parameter int IW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          upd_valid,
  input logic [3:0]    upd_op,
  input logic          upd_s,
  input logic [IW-1:0] q_instr,
  input logic          q_exec,
  input logic          q_undef,
  input logic [1:0]    st_mode,
  input logic [DW-1:0] st_x,
  input logic [DW-1:0] st_y
);
  logic [3:0] cnd;
  logic       writes;
  assign cnd    = q_instr[IW-1 -: 4];
  assign writes = upd_valid && upd_s && !(upd_op inside {4'd5, 4'd6, 4'd7});

  p_always_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cnd == 4'd14) |-> (q_exec && !q_undef));

  p_never_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cnd == 4'd15) |-> (!q_exec && !q_undef));

  p_trap_blocks_r5: assert property (@(posedge clk) disable iff (!rst_n)
    q_undef |-> !q_exec);

  p_ovf_trap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_mode == 2'd0) && (cnd == 4'd6 || cnd == 4'd7)) |-> q_undef);

  p_test_trap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_mode != 2'd0) && !(cnd inside {4'd0, 4'd1, 4'd4, 4'd5, 4'd14, 4'd15}))
      |-> q_undef);

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !writes |=> ($stable(st_x) && $stable(st_y) && $stable(st_mode)));
endmodule

bind defcmp_cond dc_chk #(.DW(DW), .IW(IW)) u_chk (
  .clk(clk), .rst_n(rst_n), .upd_valid(upd_valid), .upd_op(upd_op),
  .upd_s(upd_s), .q_instr(q_instr), .q_exec(q_exec), .q_undef(q_undef),
  .st_mode(st_mode), .st_x(st_x), .st_y(st_y)
);

// File: tb/sim_defcmp_cond.sv
`timescale 1ns/10ps
module sim_defcmp_cond;
  localparam int DW = 8;
  localparam int IW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          upd_valid = 1'b0;
  logic [3:0]    upd_op = '0;
  logic          upd_s = 1'b0;
  logic [DW-1:0] upd_a = '0, upd_b = '0, upd_res = '0;
  logic [IW-1:0] q_instr = '0;
  logic          q_exec, q_undef;

  int nchk = 0;
  int nerr = 0;
  bit done = 0;

  // model state: mode 0 compare, 1 test(AND), 2 test-equivalence(XOR)
  int            em;
  logic [DW-1:0] ex, ey;
  logic [27:0]   junk = 28'h5a5a5a5;

  always #2.5 clk = ~clk;

  defcmp_cond #(.DW(DW), .IW(IW)) u0 (
    .clk(clk), .rst_n(rst_n), .upd_valid(upd_valid), .upd_op(upd_op),
    .upd_s(upd_s), .upd_a(upd_a), .upd_b(upd_b), .upd_res(upd_res),
    .q_instr(q_instr), .q_exec(q_exec), .q_undef(q_undef)
  );

  function automatic logic [DW-1:0] val(int i);
    if (i < 16) return DW'(i * 17);
    else if (i == 16) return 8'h7f;
    else return 8'h80;
  endfunction

  function automatic string tag_of(int m, int c);
    if (c == 14 || c == 15) return "R2";
    if (m != 0) return "R6";
    if (c == 4 || c == 5) return "R4";
    if (c == 6 || c == 7) return "R5";
    return "R3";
  endfunction

  // expected {exec, undef}
  function automatic logic [1:0] expect_of(int m, logic [DW-1:0] x, logic [DW-1:0] y, int c);
    int sx, sy;
    int ux, uy;
    logic [DW-1:0] v;
    ux = int'(x); uy = int'(y);
    sx = (ux >= 128) ? ux - 256 : ux;
    sy = (uy >= 128) ? uy - 256 : uy;
    if (c == 14) return 2'b10;
    if (c == 15) return 2'b00;
    if (m == 0) begin
      case (c)
        0: return {ux == uy, 1'b0};
        1: return {ux != uy, 1'b0};
        2: return {ux >= uy, 1'b0};
        3: return {ux < uy, 1'b0};
        4: return {(((ux - uy) & 255) >= 128), 1'b0};
        5: return {(((ux - uy) & 255) < 128), 1'b0};
        8: return {ux > uy, 1'b0};
        9: return {ux <= uy, 1'b0};
        10: return {sx >= sy, 1'b0};
        11: return {sx < sy, 1'b0};
        12: return {sx > sy, 1'b0};
        13: return {sx <= sy, 1'b0};
        default: return 2'b01;
      endcase
    end
    v = (m == 1) ? (x & y) : (x ^ y);
    case (c)
      0: return {v == 0, 1'b0};
      1: return {v != 0, 1'b0};
      4: return {v[DW-1], 1'b0};
      5: return {!v[DW-1], 1'b0};
      default: return 2'b01;
    endcase
  endfunction

  // query every condition code; lower instruction bits vary (R1)
  task automatic check_all(string ctx);
    for (int c = 0; c < 16; c++) begin
      logic [1:0] e;
      junk = junk * 28'd1103 + 28'd12345;
      q_instr = {c[3:0], junk};
      #0.1;
      e = expect_of(em, ex, ey, c);
      nchk++;
      if ({q_exec, q_undef} !== e) begin
        nerr++;
        $display("FAIL %s (%s/R1) mode=%0d x=%h y=%h code=%0d: exec/undef actual=%b expected=%b",
                 tag_of(em, c), ctx, em, ex, ey, c, {q_exec, q_undef}, e);
      end
    end
  endtask

  task automatic do_upd(int op, bit s, bit v, logic [DW-1:0] a, logic [DW-1:0] b);
    logic [DW-1:0] r;
    string ctx;
    case (op)
      0: r = a & b; 1: r = a ^ b; 12: r = a | b; 13: r = b;
      14: r = a & ~b; 15: r = ~b; default: r = a + b;
    endcase
    @(negedge clk);
    upd_valid = v; upd_op = op[3:0]; upd_s = s;
    upd_a = a; upd_b = b; upd_res = r;
    check_all("R10 old state before edge");
    @(posedge clk);
    #0.5;
    upd_valid = 1'b0;
    ctx = "R9 held";
    if (v && s) begin
      case (op)
        2, 10: begin em = 0; ex = a; ey = b; ctx = "R7 sub/cmp"; end
        3: begin em = 0; ex = b; ey = a; ctx = "R7 rsb"; end
        11: begin em = 0; ex = a; ey = -b; ctx = "R7 cmn"; end
        4: begin em = 0; ex = b; ey = -a; ctx = "R7 add"; end
        8: begin em = 1; ex = a; ey = b; ctx = "R8 tst"; end
        9: begin em = 2; ex = a; ey = b; ctx = "R8 teq"; end
        0, 1, 12, 13, 14, 15: begin em = 0; ex = r; ey = 0; ctx = "R8 logic"; end
        default: ctx = "R9 op 5-7";
      endcase
    end
    check_all(ctx);
  endtask

  initial begin
    em = 0; ex = '0; ey = '0;
    #1;
    check_all("R10 in reset");
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    check_all("R10 after reset");
    for (int op = 0; op < 16; op++) begin
      for (int ia = 0; ia < 18; ia++) begin
        for (int ib = 0; ib < 18; ib++) begin
          do_upd(op, 1'b1, 1'b1, val(ia), val(ib));
          if (((ia + ib) % 5) == 0) do_upd(op, 1'b0, 1'b1, val(ib), val(ia));
          if (((ia + ib) % 7) == 0) do_upd(op, 1'b1, 1'b0, val(ib), val(ia));
        end
      end
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      nerr++;
      nchk++;
      $display("FAIL watchdog expired before the sweep finished");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end
endmodule